// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command of an SDRAM controller into the sequence of column indices that the burst visits. A command is a one-cycle strobe that carries a start column, a three-bit length code, an ordering bit (sequential or interleaved), a write flag and a single-write mode bit. The block then gives one column index per clock with a valid flag. It raises a last-beat flag on the final index of a finite burst. A stop input ends the burst early, for a burst-stop or a precharge. A new command is accepted on any clock and restarts the sequence at once. Bank, row, data and DQ timing are handled elsewhere.

The ordering is built per address bit. Bits inside the burst block take either the carry-chain sum or the XOR of the start column and the beat index. Bits above the block keep the start value. Full-page bursts use the sequential rule across the whole page, wrap from the top column to zero, and run until they are stopped.

Control is a three-state machine. IDLE gives no beats. BURST runs a finite burst of 2, 4 or 8 beats. PAGE runs a full-page burst. The transitions are as follows. *launch* goes from any state on the start strobe, to BURST for a finite length above one, to PAGE for full page, or to IDLE for a single beat. *finish* goes from BURST to IDLE after the last beat. *halt* goes from BURST or PAGE to IDLE on stop. *hold* keeps the current state when nothing happens.

Top module: `sdram_colseq`

## Requirements
- R1: The length code decodes as 000 to 1 beat, 001 to 2, 010 to 4 and 011 to 8. Code 111 with the ordering bit at 0 (sequential) selects full page.
- R2: With the ordering bit at 0, beat n of a finite burst of length L has its low log2(L) bits equal to (start + n) mod L. The upper bits equal those of the start column. A burst of 4 from column 2 gives 2,3,0,1.
- R3: With the ordering bit at 1 (interleave), beat n has its low log2(L) bits equal to the start bits XOR n, and the upper bits unchanged. A burst of 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R4: A full-page burst steps through all 8 column bits as start + n mod 256, wrapping from 255 to 0. It never raises last_beat and keeps beat_valid high until it is stopped.
- R5: When single-write mode is set, a burst with the write flag high has exactly one beat. A burst with the write flag low keeps its programmed length.
- R6: stop high in a cycle without start ends any burst, finite or full page. beat_valid is low in that cycle and stays low until the next start. stop has no effect when idle.
- R7: start is accepted in any cycle, including during a burst. The new start column appears in that same cycle, and the new sequence replaces the old one. start takes priority over stop.
- R8: A reserved length code (100, 101, 110), or 111 with the ordering bit at 1, raises cfg_error in the start cycle. The burst is then one beat long.
- R9: The first index appears with beat_valid high in the cycle start is high. last_beat is high only on beat L-1 of a finite burst. beat_valid is low when no burst runs.
- R10: After reset the block is idle, with beat_valid and last_beat low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Column command strobe |
| start_col | input | 8 | Start column of the command |
| len_code | input | 3 | Burst length code |
| ilv_order | input | 1 | 0 sequential, 1 interleaved |
| is_write | input | 1 | Command is a write |
| single_wr_mode | input | 1 | Force write bursts to one beat |
| stop | input | 1 | Burst stop or precharge request |
| col_out | output | 8 | Column index of the current beat |
| beat_valid | output | 1 | col_out carries a beat |
| last_beat | output | 1 | Current beat is the final one |
| cfg_error | output | 1 | Illegal length or ordering at start |

## Verification
The bench tests sequential wrap inside the block from start columns that are not aligned. A design that used the full carry would leak into the upper bits, for example 2,3,4,5 instead of 2,3,0,1. It tests interleave from odd starts, where an adder in place of the XOR gives a different order. It runs a full-page burst across the 255-to-0 boundary, where a design that ends the burst or raises last_beat would fail. It also covers a stop on the cycle after the first beat, a restart in the middle of a burst, a start and stop in the same cycle, single-write on writes but not reads, and every reserved code. A design that got any of these wrong would keep beats running, lose the new start column, or give the wrong beat count.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_t;

    localparam logic [2:0] LC_ONE  = 3'b000;
    localparam logic [2:0] LC_TWO  = 3'b001;
    localparam logic [2:0] LC_FOUR = 3'b010;
    localparam logic [2:0] LC_EIGHT = 3'b011;
    localparam logic [2:0] LC_PAGE = 3'b111;
endpackage

// File: rtl/colseq_len_decode.sv
module colseq_len_decode #(
    parameter int COL_W = 8,
    parameter int LOG_W = $clog2(COL_W + 1)
) (
    input  logic [2:0]       len_code,
    input  logic             ilv_order,
    input  logic             is_write,
    input  logic             single_wr_mode,
    output logic [LOG_W-1:0] blk_log2,
    output logic             full_page,
    output logic             bad_cfg
);
    import colseq_pkg::*;

    logic [LOG_W-1:0] raw_log2;
    logic             raw_full;
    logic             force_one;

    always_comb begin
        raw_log2 = '0;
        raw_full = 1'b0;
        bad_cfg  = 1'b0;
        unique case (len_code)
            LC_ONE:   raw_log2 = LOG_W'(0);
            LC_TWO:   raw_log2 = LOG_W'(1);
            LC_FOUR:  raw_log2 = LOG_W'(2);
            LC_EIGHT: raw_log2 = LOG_W'(3);
            LC_PAGE: begin
                if (ilv_order) begin
                    bad_cfg = 1'b1;
                end else begin
                    raw_log2 = LOG_W'(COL_W);
                    raw_full = 1'b1;
                end
            end
            default:  bad_cfg = 1'b1;
        endcase
    end

    assign force_one = bad_cfg || (is_write && single_wr_mode);
    assign blk_log2  = force_one ? '0 : raw_log2;
    assign full_page = force_one ? 1'b0 : raw_full;
endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
    parameter int COL_W = 8,
    parameter int LOG_W = $clog2(COL_W + 1)
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [LOG_W-1:0] blk_log2,
    input  logic             ilv_order,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum_col;
    assign sum_col = base_col + beat_idx;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        logic in_blk;
        assign in_blk = (LOG_W'(i) < blk_log2);
        assign col[i] = !in_blk   ? base_col[i] :
                        ilv_order ? (base_col[i] ^ beat_idx[i]) : sum_col[i];
    end
endmodule

// File: rtl/colseq_fsm.sv
module colseq_fsm #(
    parameter int COL_W = 8,
    parameter int LOG_W = $clog2(COL_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  logic             ilv_order,
    input  logic [LOG_W-1:0] dec_log2,
    input  logic             dec_full,
    output logic [COL_W-1:0] run_base,
    output logic [COL_W-1:0] run_idx,
    output logic [LOG_W-1:0] run_log2,
    output logic             run_ilv,
    output logic             beat_valid,
    output logic             last_beat
);
    import colseq_pkg::*;

    seq_state_t       state_q, state_d;
    logic [COL_W-1:0] base_q, idx_q, idx_d;
    logic [LOG_W-1:0] log2_q;
    logic             ilv_q;
    logic [COL_W:0]   blk_top;
    logic             at_end;

    assign blk_top = ({{COL_W{1'b0}}, 1'b1} << log2_q) - 1'b1;
    assign at_end  = ({1'b0, idx_q} == blk_top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
            log2_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (start) begin
                base_q <= start_col;
                log2_q <= dec_log2;
                ilv_q  <= ilv_order;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        beat_valid = 1'b0;
        last_beat  = 1'b0;
        if (start) begin
            beat_valid = 1'b1;
            last_beat  = !dec_full && (dec_log2 == '0);
            idx_d      = COL_W'(1);
            if (dec_full)            state_d = ST_PAGE;
            else if (dec_log2 == '0) state_d = ST_IDLE;
            else                     state_d = ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_BURST: begin
                    if (stop) begin
                        state_d = ST_IDLE;
                    end else begin
                        beat_valid = 1'b1;
                        last_beat  = at_end;
                        idx_d      = idx_q + 1'b1;
                        if (at_end) state_d = ST_IDLE;
                    end
                end
                ST_PAGE: begin
                    if (stop) begin
                        state_d = ST_IDLE;
                    end else begin
                        beat_valid = 1'b1;
                        idx_d      = idx_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign run_base = base_q;
    assign run_idx  = idx_q;
    assign run_log2 = log2_q;
    assign run_ilv  = ilv_q;
endmodule

// File: rtl/sdram_colseq.sv
module sdram_colseq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             ilv_order,
    input  logic             is_write,
    input  logic             single_wr_mode,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             beat_valid,
    output logic             last_beat,
    output logic             cfg_error
);
    localparam int LOG_W = $clog2(COL_W + 1);

    logic [LOG_W-1:0] dec_log2, run_log2;
    logic             dec_full, dec_bad, run_ilv;
    logic [COL_W-1:0] run_base, run_idx, gen_col;

    colseq_len_decode #(.COL_W(COL_W), .LOG_W(LOG_W)) u_dec (
        .len_code       (len_code),
        .ilv_order      (ilv_order),
        .is_write       (is_write),
        .single_wr_mode (single_wr_mode),
        .blk_log2       (dec_log2),
        .full_page      (dec_full),
        .bad_cfg        (dec_bad)
    );

    colseq_fsm #(.COL_W(COL_W), .LOG_W(LOG_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .start_col  (start_col),
        .ilv_order  (ilv_order),
        .dec_log2   (dec_log2),
        .dec_full   (dec_full),
        .run_base   (run_base),
        .run_idx    (run_idx),
        .run_log2   (run_log2),
        .run_ilv    (run_ilv),
        .beat_valid (beat_valid),
        .last_beat  (last_beat)
    );

    colseq_addr_gen #(.COL_W(COL_W), .LOG_W(LOG_W)) u_gen (
        .base_col  (run_base),
        .beat_idx  (run_idx),
        .blk_log2  (run_log2),
        .ilv_order (run_ilv),
        .col       (gen_col)
    );

    assign col_out   = start ? start_col : gen_col;
    assign cfg_error = start && dec_bad;
endmodule

// File: rtl/colseq_checker.sv
module colseq_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             is_write,
    input logic             single_wr_mode,
    input logic             stop,
    input logic [COL_W-1:0] col_out,
    input logic             beat_valid,
    input logic             last_beat,
    input logic             cfg_error
);
    assert_first_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (beat_valid && col_out == start_col));

    assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |-> !beat_valid);

    assert_last_has_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid);

    assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> (beat_valid == start));

    assert_burst_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !last_beat) |=> (beat_valid || stop));

    assert_error_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> (beat_valid && last_beat));

    assert_write_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_write && single_wr_mode) |-> last_beat);
endmodule

bind sdram_colseq colseq_checker #(.COL_W(COL_W)) u_colseq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .start_col      (start_col),
    .is_write       (is_write),
    .single_wr_mode (single_wr_mode),
    .stop           (stop),
    .col_out        (col_out),
    .beat_valid     (beat_valid),
    .last_beat      (last_beat),
    .cfg_error      (cfg_error)
);

// File: tb/sdram_colseq_bench.sv
`timescale 1ns/1ps
module sdram_colseq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, ilv_order = 1'b0, is_write = 1'b0;
    logic       single_wr_mode = 1'b0, stop = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic [7:0] col_out;
    logic       beat_valid, last_beat, cfg_error;
    int         checks = 0, errors = 0, cycles = 0;

    always #2.5 clk = ~clk;

    sdram_colseq u_sdram_colseq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_code(len_code), .ilv_order(ilv_order), .is_write(is_write),
        .single_wr_mode(single_wr_mode), .stop(stop), .col_out(col_out),
        .beat_valid(beat_valid), .last_beat(last_beat), .cfg_error(cfg_error)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_col(input int col, input int len, input bit ilv, input int n);
        int blk, off;
        blk = col - (col % len);
        off = col % len;
        if (ilv) return blk + (off ^ (n % len));
        return blk + ((off + n) % len);
    endfunction

    // fields: col[17:10] code[9:7] ilv[6] wr[5] srw[4] len[3:0]
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 4'd1},
        {8'h13, 3'b001, 1'b0, 1'b0, 1'b0, 4'd2},
        {8'h13, 3'b001, 1'b1, 1'b0, 1'b0, 4'd2},
        {8'h36, 3'b010, 1'b0, 1'b0, 1'b0, 4'd4},
        {8'h37, 3'b010, 1'b1, 1'b1, 1'b0, 4'd4},
        {8'hA3, 3'b011, 1'b0, 1'b0, 1'b0, 4'd8},
        {8'hFE, 3'b011, 1'b1, 1'b0, 1'b0, 4'd8},
        {8'h7B, 3'b011, 1'b0, 1'b0, 1'b1, 4'd8},
        {8'h7B, 3'b011, 1'b0, 1'b1, 1'b1, 4'd1},
        {8'h42, 3'b010, 1'b1, 1'b1, 1'b1, 4'd1},
        {8'hC9, 3'b001, 1'b1, 1'b1, 1'b0, 4'd2},
        {8'h5D, 3'b010, 1'b1, 1'b0, 1'b1, 4'd4}
    };

    task automatic launch(input logic [7:0] col, input logic [2:0] code, input bit ilv,
                          input bit wr, input bit srw);
        @(negedge clk);
        start = 1'b1; start_col = col; len_code = code;
        ilv_order = ilv; is_write = wr; single_wr_mode = srw; stop = 1'b0;
        #1;
    endtask

    task automatic step(input bit stp);
        @(negedge clk);
        start = 1'b0; stop = stp;
        #1;
    endtask

    task automatic run_burst(input logic [7:0] col, input logic [2:0] code, input bit ilv,
                             input bit wr, input bit srw, input int len, input bit err,
                             input string tag);
        int ec;
        for (int n = 0; n < len; n++) begin
            if (n == 0) launch(col, code, ilv, wr, srw);
            else step(1'b0);
            ec = model_col(int'(col), len, ilv, n);
            chk(beat_valid, {tag, " valid"}, int'(beat_valid), 1);
            chk(col_out == 8'(ec), {tag, " col"}, int'(col_out), ec);
            chk(last_beat == (n == len - 1), {tag, " R9 last"}, int'(last_beat), int'(n == len - 1));
            if (n == 0) chk(cfg_error == err, {tag, " R8 err"}, int'(cfg_error), int'(err));
        end
        step(1'b0);
        chk(!beat_valid, {tag, " R9 idle after"}, int'(beat_valid), 0);
    endtask

    task automatic run_list(input logic [7:0] col, input logic [2:0] code, input bit ilv,
                            input int exp [8], input int len, input string tag);
        for (int n = 0; n < len; n++) begin
            if (n == 0) launch(col, code, ilv, 1'b0, 1'b0);
            else step(1'b0);
            chk(col_out == 8'(exp[n]), tag, int'(col_out), exp[n]);
        end
        step(1'b0);
    endtask

    initial begin
        // R10 reset state
        #1;
        chk(!beat_valid && !last_beat, "R10 in reset", int'(beat_valid), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!beat_valid && !last_beat, "R10 after reset", int'(beat_valid), 0);

        // table walk: R1 R2 R3 R5
        for (int v = 0; v < NV; v++)
            run_burst(VEC[v][17:10], VEC[v][9:7], VEC[v][6], VEC[v][5], VEC[v][4],
                      int'(VEC[v][3:0]), 1'b0, "R1 R2 R3 R5 table");

        // R2 explicit, R3 explicit
        run_list(8'd2, 3'b010, 1'b0, '{2, 3, 0, 1, 0, 0, 0, 0}, 4, "R2 seq 4 from 2");
        run_list(8'd5, 3'b011, 1'b1, '{5, 4, 7, 6, 1, 0, 3, 2}, 8, "R3 ilv 8 from 5");

        // R8 reserved codes and illegal full page with interleave
        run_burst(8'h21, 3'b100, 1'b0, 1'b0, 1'b0, 1, 1'b1, "R8 code100");
        run_burst(8'h22, 3'b101, 1'b1, 1'b0, 1'b0, 1, 1'b1, "R8 code101");
        run_burst(8'h23, 3'b110, 1'b0, 1'b1, 1'b0, 1, 1'b1, "R8 code110");
        run_burst(8'h24, 3'b111, 1'b1, 1'b0, 1'b0, 1, 1'b1, "R8 page+ilv");

        // R4 full page across 255 -> 0, then R6 stop
        launch(8'hFC, 3'b111, 1'b0, 1'b0, 1'b0);
        chk(col_out == 8'hFC && !last_beat && !cfg_error, "R4 page first", int'(col_out), 252);
        for (int n = 1; n < 300; n++) begin
            step(1'b0);
            chk(beat_valid && !last_beat, "R4 page running", int'(last_beat), 0);
            chk(col_out == 8'((252 + n) % 256), "R4 page col", int'(col_out), (252 + n) % 256);
        end
        step(1'b1);
        chk(!beat_valid, "R6 page stop cycle", int'(beat_valid), 0);
        step(1'b0);
        chk(!beat_valid, "R6 page after stop", int'(beat_valid), 0);

        // R6 stop in a finite burst after the first beat
        launch(8'h80, 3'b011, 1'b0, 1'b0, 1'b0);
        step(1'b1);
        chk(!beat_valid && !last_beat, "R6 burst stop", int'(beat_valid), 0);
        step(1'b0);
        chk(!beat_valid, "R6 stays idle", int'(beat_valid), 0);
        step(1'b1);
        chk(!beat_valid, "R6 stop when idle", int'(beat_valid), 0);

        // R7 restart mid burst
        launch(8'h10, 3'b011, 1'b0, 1'b0, 1'b0);
        step(1'b0);
        step(1'b0);
        chk(col_out == 8'h12, "R7 old burst", int'(col_out), 8'h12);
        launch(8'h41, 3'b010, 1'b0, 1'b0, 1'b0);
        chk(beat_valid && col_out == 8'h41 && !last_beat, "R7 restart col", int'(col_out), 8'h41);
        step(1'b0);
        chk(col_out == 8'h42, "R7 restart seq1", int'(col_out), 8'h42);
        step(1'b0);
        chk(col_out == 8'h43, "R7 restart seq2", int'(col_out), 8'h43);
        step(1'b0);
        chk(col_out == 8'h40 && last_beat, "R7 restart last", int'(col_out), 8'h40);
        step(1'b0);
        chk(!beat_valid, "R7 idle", int'(beat_valid), 0);

        // R7 start wins over stop in the same cycle
        launch(8'h90, 3'b001, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b1; start_col = 8'hA5; len_code = 3'b001; ilv_order = 1'b0; stop = 1'b1;
        #1;
        chk(beat_valid && col_out == 8'hA5, "R7 start over stop", int'(col_out), 8'hA5);
        step(1'b0);
        chk(beat_valid && col_out == 8'hA4 && last_beat, "R7 after start+stop", int'(col_out), 8'hA4);
        step(1'b0);
        chk(!beat_valid, "R9 final idle", int'(beat_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule